// File: doc/BRIEF.md
# Prioritized Interrupt Distributor

This block collects interrupt requests from many sources into one table of interrupt IDs and, for each of up to eight processor ports, continuously names the single most urgent candidate ID together with its priority and group. The ID space has three classes. IDs 0 to 15 are raised only by software. IDs 16 to 31 are wired per processor. IDs from 32 upward are shared peripheral lines that are steered to processors by a per-ID target mask. The first two classes are banked per processor port, so each processor sees its own copy of their enable, pending and active bits.

Software programs the table through a simple word-wide register port. Enable, pending and active each have a separate set address and clear address. Priority and target are stored as one byte per ID, trigger mode as two bits per ID, and group as one bit per ID. A small trigger register raises a software ID on a list of processors. Acknowledge, end of interrupt and priority masking belong to a downstream per-processor block that reads the candidate outputs and drives the active bits through this port.

Top module: `irqd_top`

## Requirements
- R1: After reset the global enable is 0, every enable, pending and active bit is 0, every priority byte is 0, every shared target byte is 0, every ID from 16 upward is level-sensitive, and no candidate is presented on any port.
- R2: Bit 0 of the control word at 0x000 is the global enable. While it is 0, the valid output of every processor port is 0 one cycle later.
- R3: The set and clear pairs are enable at 0x100/0x180, pending at 0x200/0x280 and active at 0x300/0x380, each holding one bit per ID (ID n at word n/32, bit n%32). A 1 sets or clears the bit, a 0 leaves it unchanged, and both addresses of a pair read back the current state.
- R4: The priority of ID n is the byte at 0x400+n, in byte lane n%4 of its word, and reads back as written.
- R5: Each port presents the candidate with the numerically lowest priority value. Ties go to the lowest ID. The outputs are registered, so they follow a state change one clock later.
- R6: An ID is a candidate only while it is pending, enabled and not active.
- R7: A shared ID reaches port c only while bit c of its target byte at 0x800+n is set. A target of 0 reaches no port.
- R8: The enable, pending and active bits of IDs 0 to 31 are held separately for each port, and the port chosen by reg_cpu is the one accessed. For these IDs every target byte reads as 1 shifted left by reg_cpu, and writes to those bytes are ignored.
- R9: A write to 0xF00 makes the software ID in bits 3:0 pending for every port c whose bit 16+c is set. Other ports are left unchanged.
- R10: ID n has two configuration bits at 0xC00 (word n/16, lane n%16). The upper bit selects edge mode when 1 and level mode when 0. IDs 0 to 15 always read 2'b10 and ignore writes. In edge mode, a rising input edge sets the pending bit, and it stays set after the input falls until software clears it.
- R11: In level mode an ID reads pending while its input is high and it is not active, in addition to any pending bit set by software. A clear-pending write has no lasting effect while the input stays high.
- R12: The group bit of ID n is at 0x080 (word n/32, bit n%32). It reads back as written and is presented as cand_grp with the candidate of each port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | max(1,clog2(NUM_CPU)) | Port on whose behalf the access is made (selects the banked view) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ppi_line | input | NUM_CPU*16 | Per-port lines for IDs 16..31, port c at bits c*16 upward |
| spi_line | input | NUM_ID-32 | Shared lines, bit s is ID 32+s |
| cand_vld | output | NUM_CPU | A candidate is presented on port c |
| cand_id | output | NUM_CPU*clog2(NUM_ID) | Candidate ID per port |
| cand_prio | output | NUM_CPU*8 | Priority of that candidate |
| cand_grp | output | NUM_CPU | Group bit of that candidate |

## Verification
The bench builds the block with two processor ports and 64 IDs. With these values the banked half and the shared half are each one word of bitmap, and routing to one port can be checked against the other port, which stays silent. Two ports are enough to show that a banked bit written through one port is absent from the other, and that a software trigger reaches only the ports it names. Shared IDs 40 to 42 and 50 cover edge and level modes, ties on equal priority, and masking by active or disabled state.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int unsigned BANK_N = 32;   // banked IDs (software + private)
    localparam int unsigned SGI_N  = 16;   // software-raised IDs

    localparam logic [11:0] A_SGI = 12'hF00;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_GRP, RG_SEN, RG_CEN, RG_SPD, RG_CPD,
        RG_SAC, RG_CAC, RG_PRI, RG_TGT, RG_CFG, RG_SGI
    } region_e;

    function automatic region_e decode(input logic [11:0] a);
        region_e r;
        r = RG_NONE;
        case (a[11:10])
            2'b00: case (a[9:7])
                3'd0: r = (a[6:0] == 7'd0) ? RG_CTRL : RG_NONE;
                3'd1: r = RG_GRP;
                3'd2: r = RG_SEN;
                3'd3: r = RG_CEN;
                3'd4: r = RG_SPD;
                3'd5: r = RG_CPD;
                3'd6: r = RG_SAC;
                default: r = RG_CAC;
            endcase
            2'b01: r = RG_PRI;
            2'b10: r = RG_TGT;
            default: begin
                if (a[9:8] == 2'b00) r = RG_CFG;
                else if (a == A_SGI) r = RG_SGI;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqd_lines.sv
module irqd_lines #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line,
    output logic [W-1:0] rise
);
    typedef struct packed {
        logic [W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line;
        rise      = line & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int N   = 64,
    parameter int IDW = 6
) (
    input  logic [N-1:0]     cand,
    input  logic [N*8-1:0]   prio,
    output logic             found,
    output logic [IDW-1:0]   id,
    output logic [7:0]       prio_out
);
    logic [7:0] best;

    // Strict less-than while scanning upward keeps the lowest ID on a tie.
    always_comb begin
        found = 1'b0;
        id    = '0;
        best  = 8'hFF;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i*8 +: 8] < best)) begin
                found = 1'b1;
                best  = prio[i*8 +: 8];
                id    = IDW'(i);
            end
        end
        prio_out = found ? best : 8'h00;
    end
endmodule

// File: rtl/irqd_top.sv
module irqd_top
    import irqd_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_ID  = 64,
    localparam int CPUW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDW    = $clog2(NUM_ID)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [11:0]             reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [CPUW-1:0]         reg_cpu,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_CPU*16-1:0]   ppi_line,
    input  logic [NUM_ID-33:0]      spi_line,
    output logic [NUM_CPU-1:0]      cand_vld,
    output logic [NUM_CPU*IDW-1:0]  cand_id,
    output logic [NUM_CPU*8-1:0]    cand_prio,
    output logic [NUM_CPU-1:0]      cand_grp
);
    localparam int NSH   = NUM_ID - BANK_N;
    localparam int NLINE = NUM_CPU * 16 + NSH;

    typedef struct packed {
        logic                               on;
        logic [NUM_CPU-1:0][BANK_N-1:0]     b_en, b_pd, b_ac;
        logic [NSH-1:0]                     s_en, s_pd, s_ac;
        logic [NSH-1:0][7:0]                s_tgt;
        logic [NUM_ID-1:0][7:0]             pri;
        logic [NUM_ID-1:0]                  grp, edg;
        logic [NUM_CPU-1:0]                 o_vld, o_grp;
        logic [NUM_CPU-1:0][IDW-1:0]        o_id;
        logic [NUM_CPU-1:0][7:0]            o_pri;
    } st_t;

    st_t st_d, st_q;
    region_e rg;

    logic [NLINE-1:0] line_all, line_rise;
    logic [NUM_CPU-1:0][NUM_ID-1:0] v_en, v_pd, v_ac, v_cand;
    logic [NUM_CPU-1:0]             pk_found;
    logic [NUM_CPU-1:0][IDW-1:0]    pk_id;
    logic [NUM_CPU-1:0][7:0]        pk_pri;

    assign rg       = decode(reg_addr);
    assign line_all = {spi_line, ppi_line};

    irqd_lines #(.W(NLINE)) u_lines (
        .clk(clk), .rst_n(rst_n), .line(line_all), .rise(line_rise)
    );

    // Per-port view of the whole ID table.
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < BANK_N; i++) begin
                logic hi;
                hi = (i >= SGI_N) ? line_all[c*16 + (i % 16)] : 1'b0;
                v_en[c][i] = st_q.b_en[c][i];
                v_ac[c][i] = st_q.b_ac[c][i];
                v_pd[c][i] = st_q.b_pd[c][i] | (!st_q.edg[i] & hi & !st_q.b_ac[c][i]);
                v_cand[c][i] = st_q.on & v_en[c][i] & v_pd[c][i] & !v_ac[c][i];
            end
            for (int s = 0; s < NSH; s++) begin
                v_en[c][BANK_N+s] = st_q.s_en[s];
                v_ac[c][BANK_N+s] = st_q.s_ac[s];
                v_pd[c][BANK_N+s] = st_q.s_pd[s] |
                    (!st_q.edg[BANK_N+s] & line_all[NUM_CPU*16+s] & !st_q.s_ac[s]);
                v_cand[c][BANK_N+s] = st_q.on & st_q.s_en[s] & v_pd[c][BANK_N+s]
                                      & !st_q.s_ac[s] & st_q.s_tgt[s][c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
        irqd_pick #(.N(NUM_ID), .IDW(IDW)) u_pick (
            .cand(v_cand[c]), .prio(st_q.pri),
            .found(pk_found[c]), .id(pk_id[c]), .prio_out(pk_pri[c])
        );
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (reg_wr && rg == RG_CTRL) st_d.on = reg_wdata[0];
        for (int i = 0; i < NUM_ID; i++) begin
            logic wm, hit;
            wm  = reg_wr && (reg_addr[6:2] == 5'(i / 32));
            hit = wm && reg_wdata[i % 32];
            if (wm && rg == RG_GRP) st_d.grp[i] = reg_wdata[i % 32];
            if (reg_wr && rg == RG_PRI && reg_addr[9:2] == 8'(i / 4))
                st_d.pri[i] = reg_wdata[(i % 4)*8 +: 8];
            if (i >= SGI_N && reg_wr && rg == RG_CFG && reg_addr[7:2] == 6'(i / 16))
                st_d.edg[i] = reg_wdata[(i % 16)*2 + 1];
            if (i >= BANK_N) begin
                if (rg == RG_SEN && hit) st_d.s_en[i-BANK_N] = 1'b1;
                if (rg == RG_CEN && hit) st_d.s_en[i-BANK_N] = 1'b0;
                if (rg == RG_SPD && hit) st_d.s_pd[i-BANK_N] = 1'b1;
                if (rg == RG_CPD && hit) st_d.s_pd[i-BANK_N] = 1'b0;
                if (rg == RG_SAC && hit) st_d.s_ac[i-BANK_N] = 1'b1;
                if (rg == RG_CAC && hit) st_d.s_ac[i-BANK_N] = 1'b0;
                if (reg_wr && rg == RG_TGT && reg_addr[9:2] == 8'(i / 4))
                    st_d.s_tgt[i-BANK_N] = reg_wdata[(i % 4)*8 +: 8];
                if (st_q.edg[i] && line_rise[NUM_CPU*16 + i - BANK_N])
                    st_d.s_pd[i-BANK_N] = 1'b1;
            end else begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (reg_cpu == CPUW'(c)) begin
                        if (rg == RG_SEN && hit) st_d.b_en[c][i] = 1'b1;
                        if (rg == RG_CEN && hit) st_d.b_en[c][i] = 1'b0;
                        if (rg == RG_SPD && hit) st_d.b_pd[c][i] = 1'b1;
                        if (rg == RG_CPD && hit) st_d.b_pd[c][i] = 1'b0;
                        if (rg == RG_SAC && hit) st_d.b_ac[c][i] = 1'b1;
                        if (rg == RG_CAC && hit) st_d.b_ac[c][i] = 1'b0;
                    end
                    if (i >= SGI_N && st_q.edg[i] && line_rise[c*16 + (i % 16)])
                        st_d.b_pd[c][i] = 1'b1;
                    if (i < SGI_N && reg_wr && rg == RG_SGI && reg_wdata[16+c]
                        && reg_wdata[3:0] == 4'(i))
                        st_d.b_pd[c][i] = 1'b1;
                end
            end
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            st_d.o_vld[c] = pk_found[c];
            st_d.o_id[c]  = pk_id[c];
            st_d.o_pri[c] = pk_pri[c];
            st_d.o_grp[c] = pk_found[c] & st_q.grp[pk_id[c]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.edg <= NUM_ID'({SGI_N{1'b1}});
        end else begin
            st_q <= st_d;
        end
    end

    // Register read mux.
    always_comb begin
        logic [NUM_ID-1:0] r_en, r_pd, r_ac;
        r_en = '0; r_pd = '0; r_ac = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (reg_cpu == CPUW'(c)) begin
                r_en = v_en[c]; r_pd = v_pd[c]; r_ac = v_ac[c];
            end
        end
        reg_rdata = '0;
        if (rg == RG_CTRL) reg_rdata[0] = st_q.on;
        for (int i = 0; i < NUM_ID; i++) begin
            logic wm;
            wm = (reg_addr[6:2] == 5'(i / 32));
            case (rg)
                RG_GRP:         if (wm) reg_rdata[i % 32] = st_q.grp[i];
                RG_SEN, RG_CEN: if (wm) reg_rdata[i % 32] = r_en[i];
                RG_SPD, RG_CPD: if (wm) reg_rdata[i % 32] = r_pd[i];
                RG_SAC, RG_CAC: if (wm) reg_rdata[i % 32] = r_ac[i];
                RG_PRI: if (reg_addr[9:2] == 8'(i / 4))
                            reg_rdata[(i % 4)*8 +: 8] = st_q.pri[i];
                RG_TGT: if (reg_addr[9:2] == 8'(i / 4))
                            reg_rdata[(i % 4)*8 +: 8] = (i < BANK_N) ?
                                8'(1 << reg_cpu) : st_q.s_tgt[(i >= BANK_N) ? i - BANK_N : 0];
                RG_CFG: if (reg_addr[7:2] == 6'(i / 16))
                            reg_rdata[(i % 16)*2 +: 2] = {st_q.edg[i], 1'b0};
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
        assign cand_vld[c]            = st_q.o_vld[c];
        assign cand_id[c*IDW +: IDW]  = st_q.o_id[c];
        assign cand_prio[c*8 +: 8]    = st_q.o_pri[c];
        assign cand_grp[c]            = st_q.o_grp[c];

        assert_pick_is_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pk_found[c] |-> v_cand[c][pk_id[c]]);
        assert_pick_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pk_found[c] |-> (pk_pri[c] == st_q.pri[pk_id[c]]));
        assert_sgi_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && rg == RG_SGI && reg_wdata[16+c])
            |=> st_q.b_pd[c][$past(reg_wdata[3:0])]);
    end

    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.on |=> (cand_vld == '0));
    assert_zero_noeffect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && rg == RG_CEN && reg_wdata == '0) |=> ($stable(st_q.s_en) && $stable(st_q.b_en)));

endmodule

// File: tb/irqd_top_test.sv
module irqd_top_test;
    localparam int NUM_CPU = 2;
    localparam int NUM_ID  = 64;
    localparam int IDW     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [0:0]  reg_cpu = '0;
    logic [31:0] reg_rdata;
    logic [NUM_CPU*16-1:0] ppi_line = '0;
    logic [NUM_ID-33:0]    spi_line = '0;
    logic [NUM_CPU-1:0]     cand_vld, cand_grp;
    logic [NUM_CPU*IDW-1:0] cand_id;
    logic [NUM_CPU*8-1:0]   cand_prio;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    irqd_top #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .reg_rdata(reg_rdata),
        .ppi_line(ppi_line), .spi_line(spi_line), .cand_vld(cand_vld),
        .cand_id(cand_id), .cand_prio(cand_prio), .cand_grp(cand_grp)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [0:0]  wc;
        logic [11:0] ra;
        logic [0:0]  rc;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{12'h420, 32'h44332211, 1'b0, 12'h420, 1'b0, 32'h44332211, 8'd4},  // R4
        '{12'h084, 32'hA5A5A5A5, 1'b0, 12'h084, 1'b0, 32'hA5A5A5A5, 8'd12}, // R12
        '{12'h104, 32'h0000000F, 1'b0, 12'h104, 1'b0, 32'h0000000F, 8'd3},  // R3
        '{12'h184, 32'h00000005, 1'b0, 12'h104, 1'b0, 32'h0000000A, 8'd3},  // R3
        '{12'h184, 32'h00000000, 1'b0, 12'h184, 1'b0, 32'h0000000A, 8'd3},  // R3 zero
        '{12'h800, 32'hFFFFFFFF, 1'b1, 12'h800, 1'b1, 32'h02020202, 8'd8},  // R8
        '{12'h800, 32'h00000000, 1'b0, 12'h800, 1'b0, 32'h01010101, 8'd8},  // R8
        '{12'h100, 32'h00000001, 1'b0, 12'h100, 1'b1, 32'h00000000, 8'd8},  // R8 bank
        '{12'h100, 32'h00000000, 1'b0, 12'h100, 1'b0, 32'h00000001, 8'd8},  // R8 bank
        '{12'hC00, 32'h00000000, 1'b0, 12'hC00, 1'b0, 32'hAAAAAAAA, 8'd10}, // R10 fixed
        '{12'hC08, 32'h0000000A, 1'b0, 12'hC08, 1'b0, 32'h0000000A, 8'd10}, // R10
        '{12'h820, 32'h00010203, 1'b0, 12'h820, 1'b0, 32'h00010203, 8'd7}   // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [0:0] c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_cpu = c;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [0:0] c, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_cpu = c;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [NUM_ID-33:0] m);
        @(negedge clk);
        spi_line = spi_line | m;
        @(posedge clk);
        @(negedge clk);
        spi_line = spi_line & ~m;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // Table walk: write, then read back.
        for (int k = 0; k < 12; k++) begin
            wr(VECS[k].wa, VECS[k].wd, VECS[k].wc);
            rd(VECS[k].ra, VECS[k].rc, d);
            chk($sformatf("R%0d vec%0d", VECS[k].req, k), d, VECS[k].exp);
        end

        // R1: reset state
        do_reset();
        settle();
        chk("R1 vld", 32'(cand_vld), 32'h0);
        rd(12'h000, 1'b0, d); chk("R1 ctrl", d, 32'h0);
        rd(12'h428, 1'b0, d); chk("R1 prio", d, 32'h0);
        rd(12'h828, 1'b0, d); chk("R1 target", d, 32'h0);
        rd(12'hC08, 1'b0, d); chk("R1 cfg", d, 32'h0);

        wr(12'h000, 32'h1, 1'b0);
        wr(12'h428, 32'h00101030, 1'b0);
        wr(12'h828, 32'h00010101, 1'b0);
        wr(12'hC08, 32'h002A0000, 1'b0);
        wr(12'h104, 32'h00000700, 1'b0);
        settle();
        chk("R6 not pending", 32'(cand_vld), 32'h0);

        // R10: edge latches on ID 40
        pulse(32'h100);
        chk("R10 vld", 32'(cand_vld[0]), 32'h1);
        chk("R10 id", 32'(cand_id[0 +: IDW]), 32'd40);
        chk("R10 prio", 32'(cand_prio[7:0]), 32'h30);
        chk("R7 other port", 32'(cand_vld[1]), 32'h0);
        rd(12'h204, 1'b0, d); chk("R10 stays pending", d, 32'h100);

        // R5: tie between ID 41 and 42
        pulse(32'h600);
        chk("R5 tie id", 32'(cand_id[0 +: IDW]), 32'd41);
        chk("R5 prio", 32'(cand_prio[7:0]), 32'h10);

        wr(12'h304, 32'h200, 1'b0); settle();
        chk("R6 active skip", 32'(cand_id[0 +: IDW]), 32'd42);
        wr(12'h184, 32'h400, 1'b0); settle();
        chk("R6 disabled skip", 32'(cand_id[0 +: IDW]), 32'd40);
        wr(12'h084, 32'h100, 1'b0); settle();
        chk("R12 grp", 32'(cand_grp[0]), 32'h1);

        wr(12'h000, 32'h0, 1'b0); settle();
        chk("R2 off", 32'(cand_vld), 32'h0);
        wr(12'h000, 32'h1, 1'b0);

        wr(12'h284, 32'h100, 1'b0); settle();
        chk("R3 clear pend", 32'(cand_vld[0]), 32'h0);
        rd(12'h204, 1'b0, d); chk("R3 pend left", d, 32'h600);

        // R11: level ID 50 on port 1
        wr(12'h830, 32'h00020000, 1'b0);
        wr(12'h104, 32'h00040000, 1'b0);
        @(negedge clk); spi_line[18] = 1'b1;
        settle();
        chk("R11 vld", 32'(cand_vld[1]), 32'h1);
        chk("R11 id", 32'(cand_id[IDW +: IDW]), 32'd50);
        rd(12'h204, 1'b0, d); chk("R11 pend", d, 32'h40600);
        wr(12'h284, 32'h40000, 1'b0);
        rd(12'h204, 1'b0, d); chk("R11 clear no effect", d, 32'h40600);
        wr(12'h304, 32'h40000, 1'b0);
        rd(12'h204, 1'b0, d); chk("R11 active masks", d, 32'h00600);
        wr(12'h384, 32'h40000, 1'b0);
        @(negedge clk); spi_line[18] = 1'b0;
        settle();
        rd(12'h204, 1'b0, d); chk("R11 line low", d, 32'h00600);
        chk("R11 vld low", 32'(cand_vld[1]), 32'h0);

        // R9: software trigger of ID 3 to port 1 only
        wr(12'h100, 32'h8, 1'b1);
        wr(12'hF00, 32'h00020003, 1'b0);
        settle();
        chk("R9 vld", 32'(cand_vld[1]), 32'h1);
        chk("R9 id", 32'(cand_id[IDW +: IDW]), 32'd3);
        rd(12'h200, 1'b0, d); chk("R9 untargeted", d, 32'h0);
        rd(12'h200, 1'b1, d); chk("R9 targeted", d, 32'h8);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule